// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Mode Model

This block is a synthesizable behavioural model of a by-4 dynamic RAM that carries a compressed parallel test mode. A fast clock samples the active-low row strobe, column strobe and write strobe. Each falling edge of the row strobe is classified by the levels of the other two strobes at that same clock. With the column strobe high it is a row cycle, which is either an access or a refresh without a column. With the column strobe low and the write strobe high it is a column-before-row refresh. With both low it is a write-and-column-before-row cycle, which turns the test mode on.

In normal mode the two low column address bits select one of four words, and the block behaves as a plain word-wide memory. In test mode those two bits are ignored. A write copies every data bit into all four word positions of its group, and each data line is handled on its own. A read returns one flag per data line, high when the four stored bits of that line agree and low when they do not. Both views share one register array. The test mode ends on a refresh with the write strobe high, or on a row cycle in which the column strobe never falls.

Top module: `dram_ptm`

## Requirements
- R1: If the column strobe and the write strobe are both low at the clock that first samples the row strobe low, the block enters test mode from the next cycle.
- R2: If the column strobe is low and the write strobe high at that clock, the block leaves test mode, or stays in normal mode if already there.
- R3: A row cycle, meaning the column strobe is high when the row strobe falls, that ends with the row strobe rising before any column strobe fall puts the block in normal mode.
- R4: A test-mode entry cycle performed while already in test mode keeps the block in test mode.
- R5: In normal mode, an access addresses word {row, column}. All column bits count, and bits [1:0] pick one of four words. A column strobe fall with the write strobe low stores `dq_in`. With the write strobe high, the stored word is returned.
- R6: In test mode, a write stores `dq_in` into all four words that share the row and column bits [COL_W-1:2]. After the block returns to normal mode, each of those words reads back as that value.
- R7: In test mode, a read sets bit d of `dq_out` to 1 when bit d of the four words in the group are all equal, and to 0 otherwise. Column bits [1:0] have no effect on the result.
- R8: `dq_oe` is 1 only during a read access, from the clock after the column strobe is sampled low, while `oe_n` and `cas_n` are both low. It stays 0 during writes, during refresh cycles and when `oe_n` is high. `dq_out` is 0 whenever `dq_oe` is 0.
- R9: After reset the block is in normal mode, `dq_oe` is 0 and every stored bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data or per-line compare flags |
| dq_oe | output | 1 | High while `dq_out` should be driven |

## Verification
A write lands in the array at the clock edge that first samples the column strobe low. A mode change shows from the cycle after the edge that sees the row strobe fall, or for a refresh with no column, rise. Read data and `dq_oe` become valid one clock after the column strobe is sampled low, and the mode itself is only seen through later reads. The bench drives every strobe on the falling clock edge. Its monitor samples 1 ns after each falling edge, pops one expected word from the scoreboard queue on every rising `dq_oe`, and flags any drive the queue did not predict.

// File: rtl/dram_ptm_pkg.sv
package dram_ptm_pkg;

  // two low column bits form the group inside which test mode compresses
  localparam int GRP_BITS = 2;
  localparam int GRP      = 1 << GRP_BITS;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_CBR  = 2'd2,
    CYC_WCBR = 2'd3
  } cyc_e;

  // kind of cycle chosen by the strobe levels seen with the row strobe fall
  function automatic cyc_e classify(input logic cas_n, input logic we_n);
    if (cas_n)     return CYC_ROW;
    else if (!we_n) return CYC_WCBR;
    else           return CYC_CBR;
  endfunction

  // compare flag: every bit of the group carries the same value
  function automatic logic all_same(input logic [GRP-1:0] v);
    return (&v) | ~(|v);
  endfunction

endpackage

// File: rtl/dram_ptm_strobe.sv
module dram_ptm_strobe
  import dram_ptm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [AW-1:0]    addr,
  output logic             wcbr_ev,
  output logic             cbr_ev,
  output logic             ronly_end,
  output logic             access_ev,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q
);

  logic ras_q, cas_q, hit_q;
  cyc_e cyc_q, kind_now;
  logic ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign kind_now = classify(cas_n, we_n);

  assign wcbr_ev   = ras_fall && (kind_now == CYC_WCBR);
  assign cbr_ev    = ras_fall && (kind_now == CYC_CBR);
  assign ronly_end = ras_rise && (cyc_q == CYC_ROW) && !hit_q;
  assign access_ev = cas_fall && !ras_n && !ras_fall && (cyc_q == CYC_ROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      hit_q <= 1'b0;
      cyc_q <= CYC_NONE;
      row_q <= '0;
      col_q <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        cyc_q <= kind_now;
        row_q <= addr[ROW_W-1:0];
        hit_q <= 1'b0;
      end else if (ras_rise) begin
        cyc_q <= CYC_NONE;
      end
      if (access_ev) begin
        hit_q <= 1'b1;
        col_q <= addr[COL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dram_ptm_mode.sv
module dram_ptm_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic wcbr_ev,
  input  logic cbr_ev,
  input  logic ronly_end,
  output logic test_mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   test_mode <= 1'b0;
    else if (wcbr_ev)             test_mode <= 1'b1;
    else if (cbr_ev || ronly_end) test_mode <= 1'b0;
  end

endmodule

// File: rtl/dram_ptm_array.sv
module dram_ptm_array
  import dram_ptm_pkg::*;
#(
  parameter int DW    = 4,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int IW    = ROW_W + COL_W,
  localparam int DEPTH = 1 << IW,
  localparam int HW    = COL_W - GRP_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             test_mode,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [DW-1:0]    wr_data,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [DW-1:0]    rd_data
);

  function automatic logic [IW-1:0] idx(input logic [ROW_W-1:0] r,
                                         input logic [HW-1:0] h,
                                         input logic [GRP_BITS-1:0] k);
    return {r, h, k};
  endfunction

  for (genvar d = 0; d < DW; d++) begin : g_plane
    logic [DEPTH-1:0] plane;
    logic [GRP-1:0]   grp_bits;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plane <= '0;
      end else if (wr_en) begin
        for (int k = 0; k < GRP; k++) begin
          if (test_mode || (wr_col[GRP_BITS-1:0] == GRP_BITS'(k)))
            plane[idx(wr_row, wr_col[COL_W-1:GRP_BITS], GRP_BITS'(k))] <= wr_data[d];
        end
      end
    end

    always_comb begin
      for (int k = 0; k < GRP; k++)
        grp_bits[k] = plane[idx(rd_row, rd_col[COL_W-1:GRP_BITS], GRP_BITS'(k))];
    end

    assign rd_data[d] = test_mode ? all_same(grp_bits)
                                  : grp_bits[rd_col[GRP_BITS-1:0]];
  end

endmodule

// File: rtl/dram_ptm.sv
module dram_ptm
  import dram_ptm_pkg::*;
#(
  parameter int DW    = 4,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  // named internal events, also observed by the bound checker
  logic             wcbr_ev, cbr_ev, ronly_end, access_ev;
  logic             test_mode, rd_act;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    rd_data;

  dram_ptm_strobe #(.ROW_W(ROW_W), .COL_W(COL_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .wcbr_ev(wcbr_ev), .cbr_ev(cbr_ev), .ronly_end(ronly_end),
    .access_ev(access_ev), .row_q(row_q), .col_q(col_q)
  );

  dram_ptm_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wcbr_ev(wcbr_ev), .cbr_ev(cbr_ev),
    .ronly_end(ronly_end), .test_mode(test_mode)
  );

  dram_ptm_array #(.DW(DW), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(access_ev && !we_n),
    .test_mode(test_mode), .wr_row(row_q), .wr_col(addr[COL_W-1:0]),
    .wr_data(dq_in), .rd_row(row_q), .rd_col(col_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rd_act <= 1'b0;
    else if (access_ev)      rd_act <= we_n;
    else if (cas_n || ras_n) rd_act <= 1'b0;
  end

  assign dq_oe  = rd_act && !oe_n && !cas_n;
  assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/dram_ptm_check.sv
module dram_ptm_check (
  input logic clk,
  input logic rst_n,
  input logic cas_n,
  input logic we_n,
  input logic wcbr_ev,
  input logic cbr_ev,
  input logic ronly_end,
  input logic access_ev,
  input logic test_mode,
  input logic dq_oe
);

  AST_WCBR_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    wcbr_ev |=> test_mode); // R1

  AST_CBR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_ev |=> !test_mode); // R2

  AST_RONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ronly_end |=> !test_mode); // R3

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && wcbr_ev) |=> test_mode); // R4

  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wcbr_ev || cbr_ev || ronly_end) |=> $stable(test_mode)); // R1

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ev && !we_n) |=> !dq_oe); // R8

  AST_OE_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!cas_n)); // R8

endmodule

bind dram_ptm dram_ptm_check u_chk (
  .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n),
  .wcbr_ev(wcbr_ev), .cbr_ev(cbr_ev), .ronly_end(ronly_end),
  .access_ev(access_ev), .test_mode(test_mode), .dq_oe(dq_oe)
);

// File: tb/dram_ptm_test.sv
`timescale 1ns/1ps
module dram_ptm_test;

  logic       clk = 1'b0;
  logic       rst_n, ras_n, cas_n, we_n, oe_n;
  logic [3:0] addr, dq_in;
  logic [3:0] dq_out;
  logic       dq_oe;

  int  total = 0, bad = 0;
  bit  done = 0;
  bit  tm = 0;                 // bench view of the mode
  logic [3:0] bm [16][16];     // bench model [row][col]
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  dram_ptm uut (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic check(input bit ok, input string tag, input logic [3:0] act,
                       input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_read(input int r, input int c);
    logic [3:0] e;
    if (!tm) return bm[r][c];
    for (int d = 0; d < 4; d++) begin
      int ones = 0;
      for (int k = 0; k < 4; k++) ones += bm[r][(c & 12) | k][d];
      e[d] = (ones == 0) || (ones == 4);
    end
    return e;
  endfunction

  task automatic quiet(input string tag);
    #1 check(dq_oe == 1'b0, tag, {3'b0, dq_oe}, 4'h0);
  endtask

  task automatic wr(input int r, input int c, input logic [3:0] data);
    if (tm) for (int k = 0; k < 4; k++) bm[r][(c & 12) | k] = data;
    else bm[r][c] = data;
    @(negedge clk); addr = 4'(r); we_n = 1'b1; ras_n = 1'b0;
    @(negedge clk); addr = 4'(c); we_n = 1'b0; dq_in = data; cas_n = 1'b0;
    @(negedge clk); quiet("R8 write drive");
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input int r, input int c, input string tag);
    exp_q.push_back(model_read(r, c));
    tag_q.push_back(tag);
    @(negedge clk); addr = 4'(r); we_n = 1'b1; ras_n = 1'b0;
    @(negedge clk); addr = 4'(c); cas_n = 1'b0;
    @(negedge clk);
    @(negedge clk); cas_n = 1'b1;
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_no_oe(input int r, input int c);
    @(negedge clk); addr = 4'(r); we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b0;
    @(negedge clk); addr = 4'(c); cas_n = 1'b0;
    @(negedge clk); quiet("R8 oe high");
    @(negedge clk); cas_n = 1'b1;
    @(negedge clk); ras_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cbr(input logic w);
    tm = (w == 1'b0);
    @(negedge clk); cas_n = 1'b0; we_n = w;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); we_n = 1'b1; quiet("R8 refresh drive");
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk); cas_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ras_only(input int r);
    tm = 0;
    @(negedge clk); addr = 4'(r); ras_n = 1'b0;
    @(negedge clk); quiet("R8 ras-only drive");
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (dq_oe && !prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected drive", dq_out, 4'h0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dq_out === e, t, dq_out, e);
        end
      end
      prev = dq_oe;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) bm[r][c] = 4'h0;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    addr = '0; dq_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    quiet("R9 reset oe");
    check(dq_out == 4'h0, "R9 reset dq_out", dq_out, 4'h0);
    rd(0, 0, "R9 cleared array");

    wr(1, 4, 4'hA); wr(1, 5, 4'h5); wr(1, 6, 4'hC); wr(1, 7, 4'h3);
    rd(1, 4, "R5 normal col4"); rd(1, 5, "R5 normal col5");
    rd(1, 6, "R5 normal col6"); rd(1, 7, "R5 normal col7");
    rd_no_oe(1, 4);

    cbr(1'b0);                                 // enter test mode
    rd(1, 4, "R1 test read mixed group");      // expect 0000
    rd(1, 6, "R7 low column bits ignored");    // expect 0000
    wr(2, 9, 4'hB);
    rd(2, 8, "R7 replicated group equal");     // expect 1111

    cbr(1'b1);                                 // leave test mode
    rd(2, 8, "R6 copy col8"); rd(2, 9, "R6 copy col9");
    rd(2, 10, "R6 copy col10"); rd(2, 11, "R6 copy col11");
    rd(1, 5, "R2 normal after cbr exit");

    wr(2, 10, 4'h0);
    cbr(1'b0);
    cbr(1'b0);                                 // second entry keeps mode
    rd(2, 11, "R4 still in test mode");        // expect 0100

    ras_only(3);
    rd(1, 7, "R3 normal after ras-only");      // expect 3
    cbr(1'b1);
    rd(1, 4, "R2 cbr in normal mode");         // expect A

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R8 every read driven", 4'(exp_q.size()), 4'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule